// File: doc/BRIEF.md
# Configuration Image Flash Loader

This block writes a fresh configuration image into the application region of an on-chip configuration flash. The image arrives as a byte stream, and the block turns it into a series of bus transactions to a flash controller. First it opens write protection on the two application sectors. Next it erases them and polls for completion. It then packs the incoming bytes into bit-reversed 32-bit words and writes each word at a rising word address, checking the flash status after every write. When the load ends, it closes protection again. The same block can also ask the device to reboot from the application image. It does this with two writes to a small reconfiguration register window.

A load begins when `start_i` is pulsed while the block is idle. The start and end word addresses are latched in that same cycle. Bytes then move over a valid/ready handshake until the source pulses `eos_i`. A trigger pulse on `trig_i` while idle runs the reboot request instead. While any sequence runs, `busy_o` is high. When the sequence finishes, `done_o` rises, and `error_o` rises as well if any step failed. Both flags stay set until the next accepted start or trigger.

Top module: `img_flash_loader`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `error_o`, `bus_req_o` and `byte_ready_o` are all low.
- R2: A start pulse while idle latches both addresses and makes two control writes. The first writes 0xFE7FFFFF to control, which clears protect bits [24:23]. The second writes 0xFE2FFFFF to control, which keeps protection off and puts sector-erase code 3'b010 in bits [22:20]. Target codes are 0 for flash CSR, 1 for flash data and 2 for the reconfiguration window. In the CSR target, address 1 is control and address 0 is status. Every request holds its fields stable until a one-cycle `bus_ack_i`.
- R3: After the erase write, the block reads status repeatedly while bits [1:0] are non-zero. Once the erase is idle, bytes are accepted only if status bit 4 (erase ok) is set; otherwise the load fails.
- R4: Each accepted byte is bit-reversed and placed into the word. The first byte of a group goes in bits [7:0] and the fourth in bits [31:24]. Each full word is written to the data target, starting at the start address and rising by one per successful write.
- R5: After each data write, the block polls status until it is idle. If bit 3 (write ok) is clear, the load fails and no further byte is accepted.
- R6: If the stream ends with a partial group, the unused lanes are filled with 0xFF and that word is written. If the stream ends on a group boundary, no extra write is made.
- R7: If a word's address would be greater than the end address, the load fails and that word is not written.
- R8: A status read that still reports busy after POLL_TIMEOUT cycles in the poll fails the load.
- R9: Every load, whether it succeeds or fails, ends with a write of 0xFFFFFFFF to control. After that write, `busy_o` drops and `done_o` rises, with `error_o` showing whether the load failed. Both flags clear on the next accepted start or trigger.
- R10: A trigger pulse while idle writes 0x03 to reconfiguration offset 1 and then 0x01 to offset 0, after which `done_o` rises. If start and trigger arrive together, start wins.
- R11: Start and trigger pulses are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an image load (idle only) |
| trig_i | input | 1 | Request reconfiguration (idle only) |
| eos_i | input | 1 | End-of-stream strobe |
| start_addr_i | input | AW | First word address of the image |
| end_addr_i | input | AW | Last word address allowed |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Stream byte accepted when valid |
| bus_req_o | output | 1 | Bus request, held until ack |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_tgt_o | output | 2 | Target: 0 CSR, 1 data, 2 reconfiguration |
| bus_addr_o | output | AW | Address within target |
| bus_wdata_o | output | 8*WORD_BYTES | Write data |
| bus_ack_i | input | 1 | One-cycle completion |
| bus_rdata_i | input | 8*WORD_BYTES | Read data, valid with ack |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Last sequence finished |
| error_o | output | 1 | Last load failed |

## Verification
Some properties are checked on every cycle:
- a request holds its fields until it is acknowledged;
- a load opens with the unprotect value;
- no data write goes above the latched end address;
- the block stops taking bytes once the error flag is set;
- `busy_o` only drops after the protect write or the reconfiguration go write;
- the go write follows the select write directly;
- the timeout flag is never raised outside a poll.

Other behaviours only show up as complete transaction sequences in bench scenarios:
- bit reversal and lane order;
- 0xFF padding of a short last group;
- no extra write when the stream ends on a group boundary;
- the different failure paths (erase rejected, write rejected, address overflow, stuck busy);
- start and trigger pulses being ignored mid-load.

// File: rtl/img_ld_pkg.sv
package img_ld_pkg;

  typedef enum logic [1:0] {
    TGT_CSR  = 2'd0,
    TGT_DATA = 2'd1,
    TGT_RCFG = 2'd2
  } tgt_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNPROT,
    S_ERASE,
    S_POLL_ER,
    S_STREAM,
    S_WRITE,
    S_POLL_WR,
    S_REPROT,
    S_RC_SEL,
    S_RC_GO
  } st_e;

  localparam int unsigned PROT_LSB  = 23;
  localparam int unsigned ERASE_LSB = 20;
  localparam logic [2:0]  ERASE_CODE = 3'b010;

  localparam logic [31:0] CTRL_PROT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CTRL_UNPROT = CTRL_PROT & ~(32'h3 << PROT_LSB);
  localparam logic [31:0] CTRL_ERASE  = (CTRL_UNPROT & ~(32'h7 << ERASE_LSB))
                                      | ({29'd0, ERASE_CODE} << ERASE_LSB);

  localparam int unsigned CSR_STAT = 0;
  localparam int unsigned CSR_CTRL = 1;

  localparam int unsigned ST_WR_OK = 3;
  localparam int unsigned ST_ER_OK = 4;

  localparam int unsigned RC_SEL_OFS = 1;
  localparam int unsigned RC_SEL_VAL = 3;
  localparam int unsigned RC_GO_OFS  = 0;
  localparam int unsigned RC_GO_VAL  = 1;

endpackage

// File: rtl/img_byte_pack.sv
module img_byte_pack #(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW   = $clog2(LANES + 1),
  localparam int unsigned DW   = 8 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    byte_i,
  output logic [DW-1:0] word_o,
  output logic [CW-1:0] cnt_o
);

  logic [7:0]    rev;
  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;

  for (genvar b = 0; b < 8; b++) begin : g_rev
    assign rev[b] = byte_i[7-b];
  end

  // lanes start at all ones so a short group is padded with 0xFF
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '1;
      cnt_q  <= '0;
    end else if (clr_i) begin
      word_q <= '1;
      cnt_q  <= '0;
    end else if (push_i && (cnt_q < CW'(LANES))) begin
      for (int l = 0; l < LANES; l++) begin
        if (cnt_q == CW'(l)) word_q[8*l +: 8] <= rev;
      end
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/img_poll_timer.sv
module img_poll_timer #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q != TW'(LIMIT))     cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = (cnt_q == TW'(LIMIT));

  // R8
  tmo_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(run_i));

endmodule

// File: rtl/img_seq_ctrl.sv
module img_seq_ctrl
  import img_ld_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = 8 * LANES,
  localparam int unsigned CW   = $clog2(LANES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          trig_i,
  input  logic          eos_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] end_addr_i,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  input  logic [CW-1:0] pack_cnt_i,
  input  logic [DW-1:0] pack_word_i,
  output logic          pack_clr_o,
  output logic          pack_push_o,
  input  logic          tmo_i,
  output logic          poll_run_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_tgt_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q, end_q;
  logic          eos_q, done_q, err_q;
  logic          fail, set_done, adv, push, grp_full, eos_now, addr_over, stat_busy;
  logic [CW:0]   cnt_after;
  logic          unused_rdata;

  assign stat_busy    = |bus_rdata_i[1:0];
  assign unused_rdata = ^bus_rdata_i[DW-1:ST_ER_OK+1] ^ bus_rdata_i[2];

  assign byte_ready_o = (st_q == S_STREAM) && !eos_q;
  assign push         = byte_ready_o && byte_valid_i;
  assign eos_now      = eos_q || eos_i;
  assign cnt_after    = {1'b0, pack_cnt_i} + (CW+1)'(push);
  assign grp_full     = push && (pack_cnt_i == CW'(LANES - 1));
  assign addr_over    = addr_q > end_q;
  assign poll_run_o   = (st_q == S_POLL_ER) || (st_q == S_POLL_WR);

  always_comb begin
    st_d     = st_q;
    fail     = 1'b0;
    set_done = 1'b0;
    adv      = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i)     st_d = S_UNPROT;
        else if (trig_i) st_d = S_RC_SEL;
      end
      S_UNPROT: if (bus_ack_i) st_d = S_ERASE;
      S_ERASE:  if (bus_ack_i) st_d = S_POLL_ER;
      S_POLL_ER: begin
        if (bus_ack_i) begin
          if (!stat_busy) begin
            if (bus_rdata_i[ST_ER_OK]) st_d = S_STREAM;
            else                       fail = 1'b1;
          end else if (tmo_i) begin
            fail = 1'b1;
          end
        end
      end
      S_STREAM: begin
        if (grp_full || (eos_now && (cnt_after != '0))) begin
          if (addr_over) fail = 1'b1;
          else           st_d = S_WRITE;
        end else if (eos_now) begin
          st_d = S_REPROT;
        end
      end
      S_WRITE: if (bus_ack_i) st_d = S_POLL_WR;
      S_POLL_WR: begin
        if (bus_ack_i) begin
          if (!stat_busy) begin
            if (bus_rdata_i[ST_WR_OK]) begin
              adv  = 1'b1;
              st_d = S_STREAM;
            end else begin
              fail = 1'b1;
            end
          end else if (tmo_i) begin
            fail = 1'b1;
          end
        end
      end
      S_REPROT: if (bus_ack_i) begin st_d = S_IDLE;  set_done = 1'b1; end
      S_RC_SEL: if (bus_ack_i) st_d = S_RC_GO;
      S_RC_GO:  if (bus_ack_i) begin st_d = S_IDLE;  set_done = 1'b1; end
      default:  st_d = S_IDLE;
    endcase
    if (fail) st_d = S_REPROT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      end_q  <= '0;
      eos_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE) begin
        eos_q <= 1'b0;
        if (start_i) begin
          addr_q <= start_addr_i;
          end_q  <= end_addr_i;
        end
        if (start_i || trig_i) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end
      end else if (eos_i) begin
        eos_q <= 1'b1;
      end
      if (adv)      addr_q <= addr_q + AW'(1);
      if (fail)     err_q  <= 1'b1;
      if (set_done) done_q <= 1'b1;
    end
  end

  assign pack_clr_o  = (st_q == S_IDLE) || adv;
  assign pack_push_o = push;

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_tgt_o   = TGT_CSR;
    bus_addr_o  = AW'(CSR_CTRL);
    bus_wdata_o = '0;
    unique case (st_q)
      S_UNPROT:  bus_wdata_o = DW'(CTRL_UNPROT);
      S_ERASE:   bus_wdata_o = DW'(CTRL_ERASE);
      S_REPROT:  bus_wdata_o = DW'(CTRL_PROT);
      S_POLL_ER, S_POLL_WR: begin
        bus_we_o   = 1'b0;
        bus_addr_o = AW'(CSR_STAT);
      end
      S_WRITE: begin
        bus_tgt_o   = TGT_DATA;
        bus_addr_o  = addr_q;
        bus_wdata_o = pack_word_i;
      end
      S_RC_SEL: begin
        bus_tgt_o   = TGT_RCFG;
        bus_addr_o  = AW'(RC_SEL_OFS);
        bus_wdata_o = DW'(RC_SEL_VAL);
      end
      S_RC_GO: begin
        bus_tgt_o   = TGT_RCFG;
        bus_addr_o  = AW'(RC_GO_OFS);
        bus_wdata_o = DW'(RC_GO_VAL);
      end
      default: begin
        bus_req_o = 1'b0;
        bus_we_o  = 1'b0;
      end
    endcase
  end

  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                && $stable(bus_tgt_o) && $stable(bus_we_o));
  // R2
  unprot_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && bus_tgt_o == TGT_CSR && bus_we_o
      |-> bus_wdata_o == DW'(CTRL_UNPROT));
  // R5
  err_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !byte_ready_o);
  // R7
  addr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_tgt_o == TGT_DATA |-> bus_addr_o <= end_q);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  end_reprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(bus_tgt_o) == TGT_CSR && $past(bus_wdata_o) == DW'(CTRL_PROT))
                      || $past(bus_tgt_o) == TGT_RCFG);
  // R10
  rcfg_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && bus_tgt_o == TGT_RCFG && bus_addr_o == AW'(RC_SEL_OFS)
      |=> bus_req_o && bus_tgt_o == TGT_RCFG && bus_addr_o == AW'(RC_GO_OFS)
          && bus_wdata_o == DW'(RC_GO_VAL));

endmodule

// File: rtl/img_flash_loader.sv
module img_flash_loader #(
  parameter int unsigned AW           = 20,
  parameter int unsigned WORD_BYTES   = 4,
  parameter int unsigned POLL_TIMEOUT = 64,
  localparam int unsigned DW          = 8 * WORD_BYTES,
  localparam int unsigned CW          = $clog2(WORD_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          trig_i,
  input  logic          eos_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] end_addr_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  output logic          byte_ready_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_tgt_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);

  logic          pack_clr, pack_push, tmo, poll_run;
  logic [DW-1:0] pack_word;
  logic [CW-1:0] pack_cnt;

  img_byte_pack #(.LANES(WORD_BYTES)) i_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pack_clr),
    .push_i (pack_push),
    .byte_i (byte_i),
    .word_o (pack_word),
    .cnt_o  (pack_cnt)
  );

  img_poll_timer #(.LIMIT(POLL_TIMEOUT)) i_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (poll_run),
    .expired_o (tmo)
  );

  img_seq_ctrl #(.AW(AW), .LANES(WORD_BYTES)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .trig_i       (trig_i),
    .eos_i        (eos_i),
    .start_addr_i (start_addr_i),
    .end_addr_i   (end_addr_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .pack_cnt_i   (pack_cnt),
    .pack_word_i  (pack_word),
    .pack_clr_o   (pack_clr),
    .pack_push_o  (pack_push),
    .tmo_i        (tmo),
    .poll_run_o   (poll_run),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_tgt_o    (bus_tgt_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .bus_rdata_i  (bus_rdata_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o)
  );

endmodule

// File: tb/test_img_flash_loader.sv
module test_img_flash_loader;

  localparam int AW = 20;
  localparam int DW = 32;
  localparam logic [31:0] V_UNPROT = 32'hFE7F_FFFF;
  localparam logic [31:0] V_ERASE  = 32'hFE2F_FFFF;
  localparam logic [31:0] V_PROT   = 32'hFFFF_FFFF;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, trig_i = 1'b0, eos_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0, end_addr_i = '0;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          byte_ready_o;
  logic          bus_req_o, bus_we_o;
  logic [1:0]    bus_tgt_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic          busy_o, done_o, error_o;

  int checks = 0, fails = 0;

  // slave model state
  int  busy_cfg = 1, busy_left = 0, wr_idx = 0, fail_word = -1, rd_cnt = 0;
  bit  er_ok = 1'b1, stuck = 1'b0;
  int  log_n = 0;
  logic [1:0]    log_tgt  [64];
  logic [AW-1:0] log_addr [64];
  logic [31:0]   log_data [64];
  int  exp_n = 0;
  logic [1:0]    exp_tgt  [64];
  logic [AW-1:0] exp_addr [64];
  logic [31:0]   exp_data [64];
  logic [7:0]    bq [64];

  img_flash_loader i_img_flash_loader (.*);

  initial forever #5 clk_i = ~clk_i;

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk_i);
      if (bus_req_o && !bus_ack_i) begin
        bus_ack_i = 1'b1;
        if (bus_we_o) begin
          if (log_n < 64) begin
            log_tgt[log_n] = bus_tgt_o; log_addr[log_n] = bus_addr_o; log_data[log_n] = bus_wdata_o;
          end
          log_n++;
          if (bus_tgt_o == 2'd1) wr_idx++;
          busy_left = busy_cfg;
          bus_rdata_i = '0;
        end else begin
          rd_cnt++;
          if (stuck || busy_left > 0) begin
            bus_rdata_i = 32'h1;
            if (busy_left > 0) busy_left--;
          end else begin
            bus_rdata_i = 32'((er_ok ? 5'h10 : 5'h0) | ((fail_word == wr_idx - 1) ? 5'h0 : 5'h08));
          end
        end
      end else begin
        bus_ack_i = 1'b0;
      end
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int k = 0; k < 8; k++) rev8[k] = b[7-k];
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int n);
    for (int j = 0; j < 4; j++)
      exp_word[8*j +: 8] = (4*k + j < n) ? rev8(bq[4*k+j]) : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_exp(input logic [1:0] t, input logic [AW-1:0] a, input logic [31:0] d);
    exp_tgt[exp_n] = t; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask

  task automatic check_log(input string req);
    chk(log_n == exp_n, {req, " write count"}, 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_tgt[i] == exp_tgt[i] && log_addr[i] == exp_addr[i] && log_data[i] == exp_data[i],
          req, {10'(0), log_tgt[i], log_addr[i], log_data[i]},
          {10'(0), exp_tgt[i], exp_addr[i], exp_data[i]});
  endtask

  task automatic clear_log();
    log_n = 0; exp_n = 0; wr_idx = 0; rd_cnt = 0;
  endtask

  // runs a load of n bytes from bq; poke_at >= 0 pulses start and trig mid-stream
  task automatic run_load(input int n, input logic [AW-1:0] sa, input logic [AW-1:0] ea,
                          input int poke_at);
    clear_log();
    @(negedge clk_i);
    start_addr_i = sa; end_addr_i = ea; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_i = bq[i]; byte_valid_i = 1'b1;
      if (i == poke_at) begin start_i = 1'b1; trig_i = 1'b1; end
      while (!byte_ready_o && busy_o) @(negedge clk_i);
      if (!busy_o) break;
      @(negedge clk_i);
      start_i = 1'b0; trig_i = 1'b0;
    end
    byte_valid_i = 1'b0; start_i = 1'b0; trig_i = 1'b0;
    eos_i = 1'b1;
    @(negedge clk_i);
    eos_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic exp_load(input int n_words, input int n_bytes, input logic [AW-1:0] sa);
    add_exp(2'd0, AW'(1), V_UNPROT);
    add_exp(2'd0, AW'(1), V_ERASE);
    for (int k = 0; k < n_words; k++) add_exp(2'd1, sa + AW'(k), exp_word(k, n_bytes));
    add_exp(2'd0, AW'(1), V_PROT);
  endtask

  initial begin
    int unsigned rnd;
    rnd = $urandom(32'h5EED);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !done_o && !error_o, "R1 flags", {busy_o, done_o, error_o}, 0);
    chk(!bus_req_o && !byte_ready_o, "R1 bus/ready", {bus_req_o, byte_ready_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !bus_req_o, "R1 after release", {busy_o, bus_req_o}, 0);

    // R4 R6 R11: 10 bytes, partial tail, start/trig poked mid-stream
    for (int i = 0; i < 10; i++) bq[i] = 8'($urandom);
    bq[0] = 8'h01; bq[1] = 8'h80; bq[2] = 8'hC3; bq[3] = 8'h0F;
    busy_cfg = 2;
    run_load(10, 20'h100, 20'h1FF, 5);
    exp_load(3, 10, 20'h100);
    check_log("R4 R6 R11 R2 partial load");
    chk(log_data[2] == 32'hF0C3_0180, "R4 lane order/reversal", log_data[2], 32'hF0C3_0180);
    chk(done_o && !error_o && !busy_o, "R9 good finish", {done_o, error_o, busy_o}, 3'b100);

    // R6 boundary: 8 bytes -> exactly two writes
    busy_cfg = 1;
    run_load(8, 20'h40, 20'h50, -1);
    exp_load(2, 8, 20'h40);
    check_log("R6 group boundary");

    // R3 erase rejected
    er_ok = 1'b0;
    run_load(4, 20'h0, 20'hFF, -1);
    exp_load(0, 0, 20'h0);
    check_log("R3 erase fail");
    chk(error_o && done_o, "R3 error flag", {error_o, done_o}, 2'b11);
    er_ok = 1'b1;

    // R5 second write rejected
    fail_word = 1;
    for (int i = 0; i < 12; i++) bq[i] = 8'($urandom);
    run_load(12, 20'h200, 20'h2FF, -1);
    exp_load(2, 12, 20'h200);
    check_log("R5 write fail");
    chk(error_o, "R5 error flag", error_o, 1);
    fail_word = -1;

    // R7 address overflow
    run_load(12, 20'h10, 20'h11, -1);
    exp_load(2, 12, 20'h10);
    check_log("R7 overflow");
    chk(error_o, "R7 error flag", error_o, 1);

    // R8 stuck busy during erase poll
    stuck = 1'b1;
    run_load(4, 20'h0, 20'hFF, -1);
    exp_load(0, 0, 20'h0);
    check_log("R8 timeout");
    chk(error_o && rd_cnt >= 31, "R8 poll length", 64'(rd_cnt), 31);
    stuck = 1'b0;

    // R10 trigger, also clears prior error (R9)
    clear_log();
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    add_exp(2'd2, AW'(1), 32'h3);
    add_exp(2'd2, AW'(0), 32'h1);
    check_log("R10 reconfig");
    chk(done_o && !error_o, "R9 R10 flags", {done_o, error_o}, 2'b10);

    // R10 start wins over simultaneous trigger
    clear_log();
    for (int i = 0; i < 4; i++) bq[i] = 8'($urandom);
    @(negedge clk_i); start_addr_i = 20'h7; end_addr_i = 20'h7; start_i = 1'b1; trig_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; trig_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      byte_i = bq[i]; byte_valid_i = 1'b1;
      while (!byte_ready_o && busy_o) @(negedge clk_i);
      if (!busy_o) break;
      @(negedge clk_i);
    end
    byte_valid_i = 1'b0;
    eos_i = 1'b1; @(negedge clk_i); eos_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    exp_load(1, 4, 20'h7);
    check_log("R10 start priority");

    // R4 random lengths
    for (int r = 0; r < 4; r++) begin
      int n;
      logic [AW-1:0] sa;
      n  = 1 + int'($urandom % 13);
      sa = AW'($urandom % 256);
      for (int i = 0; i < n; i++) bq[i] = 8'($urandom);
      busy_cfg = int'($urandom % 3);
      run_load(n, sa, sa + AW'(20), -1);
      exp_load((n + 3) / 4, n, sa);
      check_log("R4 random stream");
      chk(!error_o && done_o, "R9 random flags", {error_o, done_o}, 2'b01);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule